// File: doc/BRIEF.md
# Load/Store Port Handshake Monitor

This block is a passive, synthesizable observer for a single load/store request port that sits between a compute unit and a small cache or buffer. It samples every port signal on each clock edge and compares what it sees with a fixed handshake contract. That contract covers five things: which request kinds may be raised together, how the busy signal frames a transaction, how long the address must be held, the single-cycle acknowledge and exception pulses, and the cycle in which busy must fall at the end of a load and at the end of a store. The block never drives the port, never models memory and never looks at data values.

The monitor runs a small state machine with five states. `ST_IDLE` means no transaction is open. `ST_ADDR` means a request has been seen and the address has not yet been accepted or refused. `ST_LOAD` means the address of a load was accepted and the monitor is waiting for load data. `ST_STORE` means the address of a store was accepted and the monitor is waiting for the store strobe. `ST_DRAIN` is the single cycle after a store strobe, in which busy must be low.

The transitions are as follows:
- IDLE to ADDR on any request.
- ADDR to LOAD or to STORE on an address acknowledge, depending on the captured request kind.
- ADDR to IDLE on an exception, or when busy drops early.
- LOAD to IDLE on the load-data strobe, or when busy drops early.
- STORE to DRAIN on the store strobe.
- STORE to IDLE when busy drops early.
- DRAIN to IDLE always.
- Any state to IDLE when die is asserted.

A transaction-end cycle is a cycle with a load-data strobe, an exception, or the DRAIN cycle. In such a cycle the request inputs are ignored, so the requester must lower its request by then. In any later IDLE cycle, a high request opens a new transaction. The first violation sets a sticky flag and records a rule code. Each clean end of a transaction produces a completion pulse.

Top module: `ldst_port_monitor`

## Requirements
- R1: Load and store requests high together in a cycle without die is a violation with code 1.
- R2: The following are violations with code 2: a request in IDLE without busy high in the same cycle; busy high in IDLE without a request; busy low in ADDR, LOAD or STORE without that state's legal ending event; while busy is high in ADDR, LOAD or STORE, a request of the kind other than the one that opened the transaction.
- R3: Once address valid has been seen high during a busy transaction cycle, address valid must remain high and the address must remain unchanged in every later cycle in which busy is high. Otherwise it is a violation with code 3.
- R4: An address acknowledge or exception outside ADDR, both in the same cycle, or an acknowledge while address valid is low is a violation with code 4. This makes each of them a single-cycle pulse, and at most one of them may occur per transaction.
- R5: An exception in ADDR must come with busy low in the same cycle; if busy is high it is a violation with code 5. An exception with busy low is a legal transaction end.
- R6: A load-data strobe outside LOAD, or in LOAD with busy still high, is a violation with code 6. A load-data strobe in LOAD with busy low is a legal transaction end.
- R7: A store strobe is legal only in STORE with busy high. In the following DRAIN cycle, busy must be low and the strobe must be low. Anything else is a violation with code 7.
- R8: The error flag and the error code (3 bits, 0 meaning no error) are 0 after reset. The first violation sets the flag and stores its code one edge later. If several rules break in the same cycle, the lowest code is stored. Both outputs then hold until reset.
- R9: The completion output is high for exactly the one cycle after a legal transaction end that has no violation in the same cycle. It is low otherwise.
- R10: Die returns the monitor to IDLE. A cycle with die raises no violation and no completion pulse, and the next cycle starts a fresh transaction check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_load | input | 1 | Load request from the compute unit |
| req_store | input | 1 | Store request from the compute unit |
| busy | input | 1 | Port busy indication from the buffer |
| addr_valid | input | 1 | Address valid from the compute unit |
| addr | input | ADDR_W | Request address |
| addr_ack | input | 1 | Address accepted pulse from the buffer |
| addr_exc | input | 1 | Address exception pulse from the buffer |
| load_done | input | 1 | Load data valid strobe from the buffer |
| store_strobe | input | 1 | Store data valid strobe from the compute unit |
| die | input | 1 | Abort: return to idle with no error |
| err_flag | output | 1 | Sticky violation flag |
| err_code | output | 3 | Code of the first violated rule |
| txn_done | output | 1 | One-cycle pulse after a clean transaction end |

## Verification
Die and a rule violation can fall in the same cycle. The bench provokes this by asserting die while busy is still high in LOAD and a stray acknowledge is present, and by asserting die in IDLE with both requests raised. The bench judges the result by the error code staying 0 and no completion pulse appearing. It then runs a full legal load, and the completion pulse that follows shows that the monitor really returned to IDLE. A legal end cycle that coincides with a stray acknowledge is checked the same way: it must produce code 4 and no completion pulse.

// File: rtl/ldst_mon_pkg.sv
package ldst_mon_pkg;

    localparam int RULE_N = 7;
    localparam int CODE_W = 3;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ADDR  = 3'd1,
        ST_LOAD  = 3'd2,
        ST_STORE = 3'd3,
        ST_DRAIN = 3'd4
    } mon_state_t;

    // Rule codes; a lower number wins when several break together.
    localparam int RC_BOTH  = 1;
    localparam int RC_BUSY  = 2;
    localparam int RC_ADDR  = 3;
    localparam int RC_ACK   = 4;
    localparam int RC_EXC   = 5;
    localparam int RC_LOAD  = 6;
    localparam int RC_STORE = 7;

    typedef struct packed {
        logic load;
        logic store;
        logic busy;
        logic addr_valid;
        logic addr_ack;
        logic addr_exc;
        logic load_done;
        logic store_strobe;
        logic die;
    } port_sample_t;

endpackage

// File: rtl/ldst_addr_tracker.sv
module ldst_addr_tracker #(
    parameter int ADDR_W = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_en,
    input  logic              clear,
    input  logic              addr_valid,
    input  logic [ADDR_W-1:0] addr,
    output logic              fault
);

    logic              seen_q;
    logic [ADDR_W-1:0] held_q;

    // Once captured, the address must stay valid and unchanged while busy.
    always_comb begin
        fault = sample_en && seen_q && (!addr_valid || (addr != held_q));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            held_q <= '0;
        end else if (clear) begin
            seen_q <= 1'b0;
        end else if (sample_en && addr_valid && !seen_q) begin
            seen_q <= 1'b1;
            held_q <= addr;
        end
    end

endmodule

// File: rtl/ldst_rule_eval.sv
module ldst_rule_eval
    import ldst_mon_pkg::*;
(
    input  mon_state_t          state,
    input  logic                kind_load,
    input  port_sample_t        p,
    input  logic                addr_fault,
    output logic [RULE_N:1]     viol,
    output mon_state_t          nxt,
    output logic                legal_end
);

    logic other_req;
    logic in_flight;

    always_comb begin
        other_req = kind_load ? p.store : p.load;
        in_flight = (state == ST_ADDR) || (state == ST_LOAD) || (state == ST_STORE);
    end

    always_comb begin
        viol      = '0;
        nxt       = state;
        legal_end = 1'b0;

        if (p.load && p.store) viol[RC_BOTH] = 1'b1;
        if (in_flight && p.busy && other_req) viol[RC_BUSY] = 1'b1;
        viol[RC_ADDR] = addr_fault;

        unique case (state)
            ST_IDLE: begin
                if (p.load || p.store) begin
                    nxt = ST_ADDR;
                    if (!p.busy) viol[RC_BUSY] = 1'b1;
                end else if (p.busy) begin
                    viol[RC_BUSY] = 1'b1;
                end
                if (p.addr_ack || p.addr_exc) viol[RC_ACK]   = 1'b1;
                if (p.load_done)              viol[RC_LOAD]  = 1'b1;
                if (p.store_strobe)           viol[RC_STORE] = 1'b1;
            end
            ST_ADDR: begin
                if (p.addr_exc) begin
                    nxt = ST_IDLE;
                    if (p.addr_ack) viol[RC_ACK] = 1'b1;
                    if (p.busy) viol[RC_EXC] = 1'b1;
                    else        legal_end    = 1'b1;
                end else if (p.addr_ack) begin
                    nxt = kind_load ? ST_LOAD : ST_STORE;
                    if (!p.addr_valid) viol[RC_ACK]  = 1'b1;
                    if (!p.busy)       viol[RC_BUSY] = 1'b1;
                end else if (!p.busy) begin
                    nxt = ST_IDLE;
                    viol[RC_BUSY] = 1'b1;
                end
                if (p.load_done)    viol[RC_LOAD]  = 1'b1;
                if (p.store_strobe) viol[RC_STORE] = 1'b1;
            end
            ST_LOAD: begin
                if (p.addr_ack || p.addr_exc) viol[RC_ACK]   = 1'b1;
                if (p.store_strobe)           viol[RC_STORE] = 1'b1;
                if (p.load_done) begin
                    nxt = ST_IDLE;
                    if (p.busy) viol[RC_LOAD] = 1'b1;
                    else        legal_end     = 1'b1;
                end else if (!p.busy) begin
                    nxt = ST_IDLE;
                    viol[RC_BUSY] = 1'b1;
                end
            end
            ST_STORE: begin
                if (p.addr_ack || p.addr_exc) viol[RC_ACK]  = 1'b1;
                if (p.load_done)              viol[RC_LOAD] = 1'b1;
                if (p.store_strobe) begin
                    nxt = ST_DRAIN;
                    if (!p.busy) viol[RC_STORE] = 1'b1;
                end else if (!p.busy) begin
                    nxt = ST_IDLE;
                    viol[RC_BUSY] = 1'b1;
                end
            end
            ST_DRAIN: begin
                nxt = ST_IDLE;
                if (p.addr_ack || p.addr_exc) viol[RC_ACK]  = 1'b1;
                if (p.load_done)              viol[RC_LOAD] = 1'b1;
                if (p.busy || p.store_strobe) viol[RC_STORE] = 1'b1;
                else                          legal_end      = 1'b1;
            end
            default: begin
                nxt = ST_IDLE;
            end
        endcase

        if (p.die) begin
            viol      = '0;
            nxt       = ST_IDLE;
            legal_end = 1'b0;
        end
    end

endmodule

// File: rtl/ldst_err_latch.sv
module ldst_err_latch
    import ldst_mon_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RULE_N:1]   viol,
    output logic              err_flag,
    output logic [CODE_W-1:0] err_code
);

    logic [CODE_W-1:0] first_code;

    // Lowest-numbered broken rule wins.
    always_comb begin
        first_code = '0;
        for (int i = RULE_N; i >= 1; i--) begin
            if (viol[i]) first_code = CODE_W'(i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_flag <= 1'b0;
            err_code <= '0;
        end else if (!err_flag && (|viol)) begin
            err_flag <= 1'b1;
            err_code <= first_code;
        end
    end

endmodule

// File: rtl/ldst_port_monitor.sv
module ldst_port_monitor
    import ldst_mon_pkg::*;
#(
    parameter int ADDR_W = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_load,
    input  logic              req_store,
    input  logic              busy,
    input  logic              addr_valid,
    input  logic [ADDR_W-1:0] addr,
    input  logic              addr_ack,
    input  logic              addr_exc,
    input  logic              load_done,
    input  logic              store_strobe,
    input  logic              die,
    output logic              err_flag,
    output logic [2:0]        err_code,
    output logic              txn_done
);

    port_sample_t     smp;
    mon_state_t       state_q;
    mon_state_t       state_d;
    logic             kind_load_q;
    logic [RULE_N:1]  viol;
    logic             legal_end;
    logic             addr_fault;
    logic             in_txn;
    logic             addr_sample_en;

    always_comb begin
        smp = '{load: req_load, store: req_store, busy: busy,
                addr_valid: addr_valid, addr_ack: addr_ack,
                addr_exc: addr_exc, load_done: load_done,
                store_strobe: store_strobe, die: die};
        in_txn = (state_q == ST_ADDR) || (state_q == ST_LOAD) ||
                 (state_q == ST_STORE) ||
                 ((state_q == ST_IDLE) && (req_load || req_store));
        addr_sample_en = in_txn && busy && !die;
    end

    ldst_addr_tracker #(.ADDR_W(ADDR_W)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_en  (addr_sample_en),
        .clear      (state_d == ST_IDLE),
        .addr_valid (addr_valid),
        .addr       (addr),
        .fault      (addr_fault)
    );

    ldst_rule_eval u_rules (
        .state      (state_q),
        .kind_load  (kind_load_q),
        .p          (smp),
        .addr_fault (addr_fault),
        .viol       (viol),
        .nxt        (state_d),
        .legal_end  (legal_end)
    );

    ldst_err_latch u_err (
        .clk      (clk),
        .rst_n    (rst_n),
        .viol     (viol),
        .err_flag (err_flag),
        .err_code (err_code)
    );

    // State register and captured request kind.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            kind_load_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if ((state_q == ST_IDLE) && (req_load || req_store) && !die)
                kind_load_q <= req_load;
        end
    end

    // Completion output.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) txn_done <= 1'b0;
        else        txn_done <= legal_end && (viol == '0);
    end

endmodule

// File: rtl/ldst_port_monitor_sva.sv
module ldst_port_monitor_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       req_load,
    input logic       req_store,
    input logic       busy,
    input logic       addr_exc,
    input logic       load_done,
    input logic       die,
    input logic       err_flag,
    input logic [2:0] err_code,
    input logic       txn_done
);

    p_both_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_load && req_store && !die) |=> err_flag);

    p_exc_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_exc && busy && !die) |=> err_flag);

    p_load_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (load_done && busy && !die) |=> err_flag);

    p_sticky_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> (err_flag && $stable(err_code)));

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        txn_done |=> !txn_done);

    p_die_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (die && !err_flag) |=> (!err_flag && !txn_done));

endmodule

bind ldst_port_monitor ldst_port_monitor_sva u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_load  (req_load),
    .req_store (req_store),
    .busy      (busy),
    .addr_exc  (addr_exc),
    .load_done (load_done),
    .die       (die),
    .err_flag  (err_flag),
    .err_code  (err_code),
    .txn_done  (txn_done)
);

// File: tb/ldst_port_monitor_bench.sv
`timescale 1ns/1ps
module ldst_port_monitor_bench;

    localparam int AW = 16;
    localparam int NV = 25;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_load = 0, req_store = 0, busy = 0, addr_valid = 0;
    logic [AW-1:0] addr = '0;
    logic          addr_ack = 0, addr_exc = 0, load_done = 0, store_strobe = 0, die = 0;
    logic          err_flag, txn_done;
    logic [2:0]    err_code;

    int n_checks = 0;
    int n_errors = 0;

    always #10 clk = ~clk;

    ldst_port_monitor #(.ADDR_W(AW)) u_ldst_port_monitor (
        .clk(clk), .rst_n(rst_n), .req_load(req_load), .req_store(req_store),
        .busy(busy), .addr_valid(addr_valid), .addr(addr), .addr_ack(addr_ack),
        .addr_exc(addr_exc), .load_done(load_done), .store_strobe(store_strobe),
        .die(die), .err_flag(err_flag), .err_code(err_code), .txn_done(txn_done)
    );

    // ctrl bits: ld st busy av ack exc ldd sts die ; then addr, exp_done, exp_code
    localparam logic [20:0] VEC [NV] = '{
        {9'b101100000, 8'h12, 1'b0, 3'd0},  // load start
        {9'b101110000, 8'h12, 1'b0, 3'd0},  // ack
        {9'b101100000, 8'h12, 1'b0, 3'd0},  // wait
        {9'b000000100, 8'h00, 1'b1, 3'd0},  // load data, busy low
        {9'b000000000, 8'h00, 1'b0, 3'd0},
        {9'b011100000, 8'h34, 1'b0, 3'd0},  // store start
        {9'b011110000, 8'h34, 1'b0, 3'd0},
        {9'b011100000, 8'h34, 1'b0, 3'd0},
        {9'b011100010, 8'h34, 1'b0, 3'd0},  // store strobe
        {9'b000000000, 8'h00, 1'b1, 3'd0},  // drain
        {9'b101000000, 8'h00, 1'b0, 3'd0},  // load start, address late
        {9'b101100000, 8'h56, 1'b0, 3'd0},
        {9'b000001000, 8'h00, 1'b1, 3'd0},  // exception, busy low
        {9'b011100000, 8'h78, 1'b0, 3'd0},
        {9'b011110000, 8'h78, 1'b0, 3'd0},
        {9'b000000001, 8'h00, 1'b0, 3'd0},  // die
        {9'b000000000, 8'h00, 1'b0, 3'd0},
        {9'b101100000, 8'h9A, 1'b0, 3'd0},
        {9'b101110000, 8'h9A, 1'b0, 3'd0},
        {9'b000000100, 8'h00, 1'b1, 3'd0},
        {9'b011100000, 8'hBC, 1'b0, 3'd0},  // back-to-back store
        {9'b011110000, 8'hBC, 1'b0, 3'd0},
        {9'b011100010, 8'hBC, 1'b0, 3'd0},
        {9'b000000000, 8'h00, 1'b1, 3'd0},
        {9'b000000000, 8'h00, 1'b0, 3'd0}
    };

    task automatic chk(input string tag, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
        end
    endtask

    task automatic step(input logic [8:0] c, input logic [7:0] a);
        @(negedge clk);
        {req_load, req_store, busy, addr_valid, addr_ack, addr_exc,
         load_done, store_strobe, die} = c;
        addr = {8'h00, a};
        @(posedge clk);
        #2;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        {req_load, req_store, busy, addr_valid, addr_ack, addr_exc,
         load_done, store_strobe, die} = '0;
        addr = '0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #2;
    endtask

    initial begin
        #(20 * 100000);
        n_errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        do_reset();
        // R11-style reset state, covered by R8
        chk("R8 reset flag", int'(err_flag), 0);
        chk("R8 reset code", int'(err_code), 0);
        chk("R9 reset done", int'(txn_done), 0);

        // Legal flows
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][20:12], VEC[i][11:4]);
            chk($sformatf("R9 done row %0d", i), int'(txn_done), int'(VEC[i][3]));
            chk($sformatf("R2 code row %0d", i), int'(err_code), int'(VEC[i][2:0]));
        end

        // R1 both requests
        do_reset();
        step(9'b111000000, 8'h01);
        chk("R1 both requests", int'(err_code), 1);

        // R8 priority and stickiness
        do_reset();
        step(9'b110000000, 8'h01);
        chk("R8 lowest code wins", int'(err_code), 1);
        step(9'b001001000, 8'h00);
        step(9'b000000000, 8'h00);
        chk("R8 code held", int'(err_code), 1);
        chk("R8 flag held", int'(err_flag), 1);

        // R2 variants
        do_reset();
        step(9'b100000000, 8'h01);
        chk("R2 request without busy", int'(err_code), 2);
        do_reset();
        step(9'b101100000, 8'h01);
        step(9'b101110000, 8'h01);
        step(9'b101100000, 8'h01);
        chk("R2 no error before drop", int'(err_code), 0);
        step(9'b100000000, 8'h01);
        chk("R2 busy dropped early", int'(err_code), 2);
        do_reset();
        step(9'b101100000, 8'h01);
        step(9'b011100000, 8'h01);
        chk("R2 other request while busy", int'(err_code), 2);

        // R3 address hold
        do_reset();
        step(9'b101100000, 8'h11);
        step(9'b101100000, 8'h22);
        chk("R3 address changed", int'(err_code), 3);
        do_reset();
        step(9'b101100000, 8'h11);
        step(9'b101000000, 8'h11);
        chk("R3 valid dropped", int'(err_code), 3);

        // R4 ack rules
        do_reset();
        step(9'b101100000, 8'h01);
        step(9'b101110000, 8'h01);
        step(9'b101110000, 8'h01);
        chk("R4 second ack", int'(err_code), 4);
        do_reset();
        step(9'b101000000, 8'h01);
        step(9'b101010000, 8'h01);
        chk("R4 ack without valid", int'(err_code), 4);
        do_reset();
        step(9'b101100000, 8'h01);
        step(9'b101110000, 8'h01);
        step(9'b000010100, 8'h00);
        chk("R4 stray ack at load end", int'(err_code), 4);
        chk("R9 no done on faulty end", int'(txn_done), 0);

        // R5 exception
        do_reset();
        step(9'b101100000, 8'h01);
        step(9'b101101000, 8'h01);
        chk("R5 exception with busy", int'(err_code), 5);
        do_reset();
        step(9'b011100000, 8'h01);
        step(9'b000001000, 8'h00);
        chk("R5 legal exception done", int'(txn_done), 1);
        chk("R5 legal exception code", int'(err_code), 0);

        // R6 load strobe with busy
        do_reset();
        step(9'b101100000, 8'h01);
        step(9'b101110000, 8'h01);
        step(9'b101100100, 8'h01);
        chk("R6 load data with busy", int'(err_code), 6);

        // R7 store strobe rules
        do_reset();
        step(9'b011100000, 8'h01);
        step(9'b011100010, 8'h01);
        chk("R7 strobe before ack", int'(err_code), 7);
        do_reset();
        step(9'b011100000, 8'h01);
        step(9'b011110000, 8'h01);
        step(9'b011100010, 8'h01);
        step(9'b000000010, 8'h00);
        chk("R7 strobe two cycles", int'(err_code), 7);
        do_reset();
        step(9'b011100000, 8'h01);
        step(9'b011110000, 8'h01);
        step(9'b011100010, 8'h01);
        step(9'b011100000, 8'h01);
        chk("R7 busy held after strobe", int'(err_code), 7);
        do_reset();
        step(9'b011100000, 8'h01);
        step(9'b011110000, 8'h01);
        step(9'b000000010, 8'h00);
        chk("R7 busy low at strobe", int'(err_code), 7);

        // R10 die
        do_reset();
        step(9'b101100000, 8'h01);
        step(9'b101110000, 8'h01);
        step(9'b001010001, 8'h01);
        chk("R10 die masks errors", int'(err_code), 0);
        chk("R10 die no done", int'(txn_done), 0);
        step(9'b110000001, 8'h00);
        chk("R10 die in idle", int'(err_flag), 0);
        step(9'b101100000, 8'h05);
        step(9'b101110000, 8'h05);
        step(9'b000000100, 8'h00);
        chk("R10 fresh load after die", int'(txn_done), 1);
        chk("R10 fresh load code", int'(err_code), 0);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule